// File: doc/BRIEF.md
# Serial Bus Control and Line Condition Detector

This block is the control and status register of a clocked serial port that runs on two or three wires. Software writes trigger bits that act on the serial output latch. One trigger forces the latch high, which puts a bus release condition on the line. Another trigger forces the latch low, which puts a command condition on the line. A third trigger sends one acknowledge bit, timed by the serial clock.

The block watches the incoming data and clock lines through two-flop synchronizers. It raises a release flag when the data line rises while the clock is high. It raises a command flag when the data line falls while the clock is high. Each flag has its own set of clearing events: the start of a transfer, a received address that does not match, a release on the line, and the port being disabled.

The shift register and the address comparator are outside this block. They report to it through the transfer-start, transfer-done, address-received and address-match inputs.

Top module: `sbus_ctl`

## Requirements
- R1: A write with bit 0 set drives the serial output latch to 1, and `so_out` follows one cycle later. Bit 0 always reads back as 0.
- R2: A write with bit 1 set (and bit 0 clear) drives the output latch to 0. Bit 1 always reads back as 0. When bits 0 and 1 are set in the same write, the latch becomes 1.
- R3: `sdi_in` rising while `sck_in` is high sets the release flag, which reads at bit 2. A data change while the clock is low sets no flag.
- R4: The release flag is cleared by `xfer_start`. It is also cleared by `addr_rx` when `addr_match` is 0. An `addr_rx` with `addr_match` at 1 leaves the flag set.
- R5: `sdi_in` falling while `sck_in` is high sets the command flag, which reads at bit 3.
- R6: The command flag is cleared by `xfer_start` and by detection of a release condition.
- R7: While `port_en` is 0, both flags are held at 0, even when line conditions occur.
- R8: Writing 1 to bit 4 while no transfer is in progress arms an acknowledge, and bit 4 reads 1 while it is pending. From the next falling edge of `sck_in` through the end of the following high phase, `so_out` is 0. After that, `so_out` returns to the latch value and bit 4 reads 0.
- R9: A write of 1 to bit 4 between `xfer_start` and `xfer_done` is ignored.
- R10: Writing 0 to bit 4 does not cancel a pending acknowledge.
- R11: Writes to bits 2 and 3 have no effect on the flags.
- R12: After reset, `so_out` is 1 and `reg_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Serial port enable; 0 holds both flags clear |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 5 | Write data: bit0 release trigger, bit1 command trigger, bit4 acknowledge trigger |
| reg_rdata | output | 5 | Registered read data: bit2 release flag, bit3 command flag, bit4 acknowledge pending |
| sck_in | input | 1 | Serial clock line (asynchronous) |
| sdi_in | input | 1 | Serial data line (asynchronous) |
| xfer_start | input | 1 | One-cycle pulse when a transfer starts |
| xfer_done | input | 1 | One-cycle pulse when a transfer completes |
| addr_rx | input | 1 | One-cycle pulse when an address byte has been received |
| addr_match | input | 1 | Address comparison result, valid with `addr_rx` |
| so_out | output | 1 | Registered serial data output |

## Verification
The data line is moved in four ways: rising and falling while the clock is high, and rising and falling while the clock is low. These separate a genuine release from a genuine command, and both from ordinary data movement. Every clearing event is applied to a flag that is already set, and an address receipt with a match is also applied, so that real clearing is told apart from flags that were never raised. The acknowledge is followed through a full low-then-high serial clock cycle. This shows that the output is pulled low only for that window, and that a write made during a transfer or a write of 0 does not change the pending state.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  localparam int REG_W       = 5;
  localparam int BIT_REL_TRG = 0;
  localparam int BIT_CMD_TRG = 1;
  localparam int BIT_REL_FLG = 2;
  localparam int BIT_CMD_FLG = 3;
  localparam int BIT_ACK     = 4;

  typedef enum logic [1:0] {
    ACK_IDLE  = 2'd0,
    ACK_ARMED = 2'd1,
    ACK_LOW   = 2'd2,
    ACK_HIGH  = 2'd3
  } ack_state_t;
endpackage

// File: rtl/sbus_sync.sv
module sbus_sync #(
  parameter int STAGES  = 2,
  parameter int W       = 1,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= RST_VAL;
      else if (s == 0) chain[s] <= d;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sbus_cond_det.sv
module sbus_cond_det (
  input  logic clk,
  input  logic rst,
  input  logic sck_s,
  input  logic sdi_s,
  output logic rel_det,
  output logic cmd_det,
  output logic sck_fall,
  output logic sck_rise
);
  logic sck_q, sdi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= 1'b1;
      sdi_q <= 1'b1;
    end else begin
      sck_q <= sck_s;
      sdi_q <= sdi_s;
    end
  end

  // Data edges count only while the clock stays high across both samples.
  assign rel_det  = sck_s & sck_q & sdi_s & ~sdi_q;
  assign cmd_det  = sck_s & sck_q & ~sdi_s & sdi_q;
  assign sck_fall = ~sck_s & sck_q;
  assign sck_rise = sck_s & ~sck_q;
endmodule

// File: rtl/sbus_ack_gen.sv
module sbus_ack_gen
  import sbus_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic sck_fall,
  input  logic sck_rise,
  output logic pend,
  output logic active,
  output logic done
);
  ack_state_t st, st_nx;

  always_comb begin
    st_nx = st;
    done  = 1'b0;
    unique case (st)
      ACK_IDLE:  if (arm) st_nx = ACK_ARMED;
      ACK_ARMED: if (sck_fall) st_nx = ACK_LOW;
      ACK_LOW:   if (sck_rise) st_nx = ACK_HIGH;
      ACK_HIGH:  if (sck_fall) begin
                   st_nx = ACK_IDLE;
                   done  = 1'b1;
                 end
      default:   st_nx = ACK_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ACK_IDLE;
    else     st <= st_nx;
  end

  assign pend   = (st != ACK_IDLE);
  assign active = (st == ACK_LOW) || (st == ACK_HIGH);
endmodule

// File: rtl/sbus_ctl.sv
module sbus_ctl
  import sbus_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             port_en,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             sck_in,
  input  logic             sdi_in,
  input  logic             xfer_start,
  input  logic             xfer_done,
  input  logic             addr_rx,
  input  logic             addr_match,
  output logic             so_out
);
  logic [1:0] line_s;
  logic rel_det, cmd_det, sck_fall, sck_rise;
  logic ack_pend, ack_active, ack_done, ack_arm;
  logic so_latch, rel_flag, cmd_flag, busy;

  sbus_sync #(.STAGES(SYNC_STAGES), .W(2), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst(rst), .d({sck_in, sdi_in}), .q(line_s)
  );

  sbus_cond_det u_det (
    .clk(clk), .rst(rst), .sck_s(line_s[1]), .sdi_s(line_s[0]),
    .rel_det(rel_det), .cmd_det(cmd_det),
    .sck_fall(sck_fall), .sck_rise(sck_rise)
  );

  assign ack_arm = reg_we & reg_wdata[BIT_ACK] & ~busy;

  sbus_ack_gen u_ack (
    .clk(clk), .rst(rst), .arm(ack_arm),
    .sck_fall(sck_fall), .sck_rise(sck_rise),
    .pend(ack_pend), .active(ack_active), .done(ack_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      so_latch <= 1'b1;
      busy     <= 1'b0;
      rel_flag <= 1'b0;
      cmd_flag <= 1'b0;
      so_out   <= 1'b1;
      reg_rdata <= '0;
    end else begin
      if (reg_we && reg_wdata[BIT_REL_TRG])      so_latch <= 1'b1;
      else if (reg_we && reg_wdata[BIT_CMD_TRG]) so_latch <= 1'b0;

      if (xfer_start)     busy <= 1'b1;
      else if (xfer_done) busy <= 1'b0;

      if (!port_en || xfer_start || (addr_rx && !addr_match)) rel_flag <= 1'b0;
      else if (rel_det)                                        rel_flag <= 1'b1;

      if (!port_en || xfer_start || rel_det) cmd_flag <= 1'b0;
      else if (cmd_det)                      cmd_flag <= 1'b1;

      so_out <= ack_active ? 1'b0 : so_latch;

      reg_rdata              <= '0;
      reg_rdata[BIT_REL_FLG] <= rel_flag;
      reg_rdata[BIT_CMD_FLG] <= cmd_flag;
      reg_rdata[BIT_ACK]     <= ack_pend;
    end
  end
endmodule

// File: rtl/sbus_ctl_chk.sv
module sbus_ctl_chk
  import sbus_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             port_en,
  input logic             reg_we,
  input logic [REG_W-1:0] reg_wdata,
  input logic             xfer_start,
  input logic             so_out,
  input logic             so_latch,
  input logic             rel_flag,
  input logic             cmd_flag,
  input logic             rel_det,
  input logic             ack_pend,
  input logic             ack_active,
  input logic             ack_done,
  input logic             busy
);
  // R1
  rel_trig_chk: assert property (@(posedge clk) disable iff (rst)
    reg_we && reg_wdata[BIT_REL_TRG] |=> so_latch);
  // R2
  cmd_trig_chk: assert property (@(posedge clk) disable iff (rst)
    reg_we && reg_wdata[BIT_CMD_TRG] && !reg_wdata[BIT_REL_TRG] |=> !so_latch);
  // R4
  start_clr_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_start |=> !rel_flag && !cmd_flag);
  // R6
  rel_clr_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    rel_det |=> !cmd_flag);
  // R7
  dis_clr_chk: assert property (@(posedge clk) disable iff (rst)
    !port_en |=> !rel_flag && !cmd_flag);
  // R8
  ack_low_chk: assert property (@(posedge clk) disable iff (rst)
    ack_active |=> !so_out);
  // R9
  ack_busy_chk: assert property (@(posedge clk) disable iff (rst)
    reg_we && reg_wdata[BIT_ACK] && busy && !ack_pend |=> !ack_pend);
  // R10
  ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ack_pend && !ack_done |=> ack_pend);
endmodule

bind sbus_ctl sbus_ctl_chk u_chk (
  .clk(clk), .rst(rst), .port_en(port_en), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .xfer_start(xfer_start), .so_out(so_out),
  .so_latch(so_latch), .rel_flag(rel_flag), .cmd_flag(cmd_flag),
  .rel_det(rel_det), .ack_pend(ack_pend), .ack_active(ack_active),
  .ack_done(ack_done), .busy(busy)
);

// File: tb/sbus_ctl_bench.sv
module sbus_ctl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic port_en = 1'b1, reg_we = 1'b0;
  logic [4:0] reg_wdata = '0;
  logic [4:0] reg_rdata;
  logic sck_in = 1'b1, sdi_in = 1'b1;
  logic xfer_start = 1'b0, xfer_done = 1'b0, addr_rx = 1'b0, addr_match = 1'b0;
  logic so_out;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  sbus_ctl u_sbus_ctl (
    .clk(clk), .rst(rst), .port_en(port_en), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck_in(sck_in),
    .sdi_in(sdi_in), .xfer_start(xfer_start), .xfer_done(xfer_done),
    .addr_rx(addr_rx), .addr_match(addr_match), .so_out(so_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] d);
    @(negedge clk); reg_we = 1'b1; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse_start();
    @(negedge clk); xfer_start = 1'b1;
    @(negedge clk); xfer_start = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
  endtask

  task automatic line(input logic sck, input logic sdi);
    @(negedge clk); sck_in = sck; sdi_in = sdi;
    idle(6);
  endtask

  task automatic t_reset();
    idle(2);
    chk("R12 so_out", so_out, 1);
    chk("R12 rdata", reg_rdata, 0);
  endtask

  task automatic t_triggers();
    wr(5'b00010); idle(2);
    chk("R2 so low", so_out, 0);
    chk("R2 bit1 reads 0", reg_rdata[1], 0);
    wr(5'b00001); idle(2);
    chk("R1 so high", so_out, 1);
    chk("R1 bit0 reads 0", reg_rdata[0], 0);
    wr(5'b00010); idle(2);
    wr(5'b00011); idle(2);
    chk("R2 both set release wins", so_out, 1);
  endtask

  task automatic t_detect();
    line(1, 1);
    line(1, 0);
    chk("R5 cmd flag", reg_rdata[3], 1);
    chk("R5 no rel", reg_rdata[2], 0);
    line(1, 1);
    chk("R3 rel flag", reg_rdata[2], 1);
    chk("R6 cmd cleared by release", reg_rdata[3], 0);
    pulse_start(); idle(3);
    chk("R4 start clears rel", reg_rdata[2], 0);
    pulse_done();
    line(0, 1); line(0, 0); line(0, 1); line(1, 1);
    chk("R3 no flags when clock low", reg_rdata[3:2], 0);
    line(1, 0);
    pulse_start(); idle(3);
    chk("R6 start clears cmd", reg_rdata[3], 0);
    pulse_done();
  endtask

  task automatic t_addr();
    line(1, 0); line(1, 1);
    @(negedge clk); addr_rx = 1'b1; addr_match = 1'b1;
    @(negedge clk); addr_rx = 1'b0; addr_match = 1'b0;
    idle(3);
    chk("R4 match keeps rel", reg_rdata[2], 1);
    wr(5'b01100); idle(3);
    chk("R11 write ignored on flags", reg_rdata[3:2], 2'b01);
    @(negedge clk); addr_rx = 1'b1;
    @(negedge clk); addr_rx = 1'b0;
    idle(3);
    chk("R4 mismatch clears rel", reg_rdata[2], 0);
    wr(5'b01100); idle(3);
    chk("R11 write cannot set flags", reg_rdata[3:2], 0);
  endtask

  task automatic t_disable();
    line(1, 0);
    chk("R7 precondition cmd", reg_rdata[3], 1);
    @(negedge clk); port_en = 1'b0;
    idle(3);
    chk("R7 cmd cleared", reg_rdata[3], 0);
    line(1, 1);
    chk("R7 release blocked", reg_rdata[2], 0);
    @(negedge clk); port_en = 1'b1;
    idle(2);
  endtask

  task automatic t_ack();
    wr(5'b00001); idle(2);
    pulse_start();
    wr(5'b10000); idle(3);
    chk("R9 ack ignored in transfer", reg_rdata[4], 0);
    pulse_done();
    wr(5'b10000); idle(3);
    chk("R8 ack pending", reg_rdata[4], 1);
    chk("R8 so before clock fall", so_out, 1);
    wr(5'b00000); idle(3);
    chk("R10 write 0 keeps ack", reg_rdata[4], 1);
    line(0, 1);
    chk("R8 so low after fall", so_out, 0);
    line(1, 1);
    chk("R8 so low in high phase", so_out, 0);
    line(0, 1);
    chk("R8 so back to latch", so_out, 1);
    chk("R8 ack cleared", reg_rdata[4], 0);
    line(1, 1);
  endtask

  initial begin
    idle(3);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_triggers();
    t_detect();
    t_addr();
    t_disable();
    t_ack();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule